// File: doc/BRIEF.md
# Three-Channel Match and Wrap Timer

This peripheral holds three identical 32-bit counters behind a small synchronous register port. Each counter has a reload value, two compare values, a direction, an enable, and a tick source. The tick source is either every bus clock cycle or the rising edges of its own external tick pin. A counter that runs past its end (up through all ones, or down through zero) takes its reload value and raises an overflow flag. A counter that steps onto either compare value raises that compare's flag.

All nine flags sit in one sticky status word, three bits per channel. A mask word of the same layout selects which flags drive that channel's interrupt line. The overflow term is also gated by a per-channel enable in the control word. A periodic tick is made by loading `0xFFFFFFFF - (P - 1)` and counting up. A one-shot event is made by writing the current count plus a delta into a compare register.

Reads are registered: `rd_data` shows, one cycle later, the register addressed on the cycle before.

Top module: `tri_match_timer`

## Requirements
- R1: After a synchronous reset every register reads as zero and all three `irq` bits are low.
- R2: Register map by byte address. For channel n the count is at 0x10·n, the reload at 0x10·n+4, compare A at 0x10·n+8 and compare B at 0x10·n+0xC. Control is at 0x30 (12 bits), status at 0x34 (9 bits) and mask at 0x38 (9 bits). Unimplemented bits and unmapped addresses read as zero. `rd_data` returns the addressed register one clock after the address is presented.
- R3: With control bit 9+n set, channel n counts up. A step from 0xFFFFFFFF loads the reload value and sets status bit 3n+2, so a reload of 0xFFFFFFFF-(P-1) overflows every P ticks.
- R4: With control bit 9+n clear, channel n counts down. A step from 0 loads the reload value and sets status bit 3n+2.
- R5: A step that brings channel n's count to compare A sets status bit 3n. A step that brings it to compare B sets status bit 3n+1.
- R6: While control bit 3n is clear, channel n's count holds its value. A write to the count register sets the value from which counting resumes.
- R7: With control bit 3n+1 set, channel n steps once per rising edge of `ext_tick[n]`, seen through a two-stage synchronizer. A level held on the pin produces no steps.
- R8: Status bits are sticky. A write to 0x34 replaces the status word, but a hardware event in the same cycle still sets its bit.
- R9: `irq[n]` is registered one cycle after status. It is high when (status & mask) is non-zero in bits 3n or 3n+1, or in bit 3n+2 while control bit 3n+2 is set. A cleared mask bit blocks its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 6 | Byte address of the register |
| wr_en | input | 1 | Write strobe for the addressed register |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| ext_tick | input | 3 | Per-channel external tick inputs |
| irq | output | 3 | Per-channel interrupt lines |

## Verification
The hardest case to reach from the ports is a software clear of the status word landing on the exact cycle in which the hardware raises an overflow. The bench gets there by loading a reload value that gives a short period and starting the counter with a control write. It then counts bus cycles from that write edge so that the status write lands on the overflow edge. A second clear, issued off the event cycle, shows the same write does clear the flag. The external tick path is checked by counting whole pulses after holding the pin at a steady level.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NCH       = 3;
  localparam int FLAGS_PER = 3;
  localparam int STAT_W    = NCH * FLAGS_PER;
  localparam int CTRL_W    = NCH * 4;
  localparam int ADDR_W    = 6;
  localparam int SYNC_LEN  = 2;
  // word indices (byte address / 4)
  localparam logic [3:0] WORD_CTRL = 4'hC;
  localparam logic [3:0] WORD_STAT = 4'hD;
  localparam logic [3:0] WORD_MASK = 4'hE;
  // slots inside a channel window
  localparam int SLOT_CNT  = 0;
  localparam int SLOT_LOAD = 1;
  localparam int SLOT_CMPA = 2;
  localparam int SLOT_CMPB = 3;
endpackage

// File: rtl/tmr_tick_sync.sv
module tmr_tick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], pin};
  end

  assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         count_up,
  input  logic         step,
  input  logic [3:0]   wr_slot,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt,
  output logic [W-1:0] reload,
  output logic [W-1:0] cmp_a,
  output logic [W-1:0] cmp_b,
  output logic         hit_a,
  output logic         hit_b,
  output logic         wrapped
);
  import tmr_pkg::*;

  logic         advance;
  logic         at_end;
  logic [W-1:0] next_val;

  always_comb begin
    advance  = run & step & ~wr_slot[SLOT_CNT];
    at_end   = count_up ? (cnt == '1) : (cnt == '0);
    if (at_end)        next_val = reload;
    else if (count_up) next_val = cnt + W'(1);
    else               next_val = cnt - W'(1);
    wrapped  = advance & at_end;
    hit_a    = advance & (next_val == cmp_a);
    hit_b    = advance & (next_val == cmp_b);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      reload <= '0;
      cmp_a  <= '0;
      cmp_b  <= '0;
    end else begin
      if (wr_slot[SLOT_CNT])      cnt <= wdata;
      else if (advance)           cnt <= next_val;
      if (wr_slot[SLOT_LOAD])     reload <= wdata;
      if (wr_slot[SLOT_CMPA])     cmp_a  <= wdata;
      if (wr_slot[SLOT_CMPB])     cmp_b  <= wdata;
    end
  end
endmodule

// File: rtl/tmr_irq_ctl.sv
module tmr_irq_ctl #(
  parameter int NCH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_stat,
  input  logic [NCH*3-1:0] wdata,
  input  logic [NCH*3-1:0] events,
  input  logic [NCH*3-1:0] mask,
  input  logic [NCH-1:0]   ovf_en,
  output logic [NCH*3-1:0] status,
  output logic [NCH-1:0]   irq
);
  logic [NCH-1:0] pend;

  always_ff @(posedge clk) begin
    if (rst)          status <= '0;
    else if (wr_stat) status <= wdata | events;
    else              status <= status | events;
  end

  for (genvar n = 0; n < NCH; n++) begin : g_line
    logic [2:0] live;
    assign live    = status[3*n +: 3] & mask[3*n +: 3];
    assign pend[n] = live[0] | live[1] | (live[2] & ovf_en[n]);
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= '0;
    else     irq <= pend;
  end
endmodule

// File: rtl/tri_match_timer.sv
module tri_match_timer #(
  parameter int W = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [tmr_pkg::ADDR_W-1:0]    addr,
  input  logic                          wr_en,
  input  logic [W-1:0]                  wdata,
  output logic [W-1:0]                  rd_data,
  input  logic [tmr_pkg::NCH-1:0]       ext_tick,
  output logic [tmr_pkg::NCH-1:0]       irq
);
  import tmr_pkg::*;

  logic [3:0]                word;
  logic [1:0]                unused_byte;
  logic [CTRL_W-1:0]         ctrl;
  logic [STAT_W-1:0]         mask;
  logic [STAT_W-1:0]         status;
  logic [STAT_W-1:0]         events;
  logic [NCH-1:0]            ovf_en;
  logic [NCH-1:0][W-1:0]     cnt_q, load_q, cmpa_q, cmpb_q;
  logic [W-1:0]              rd_next;

  assign word        = addr[5:2];
  assign unused_byte = addr[1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
      mask <= '0;
    end else if (wr_en) begin
      if (word == WORD_CTRL) ctrl <= wdata[CTRL_W-1:0];
      if (word == WORD_MASK) mask <= wdata[STAT_W-1:0];
    end
  end

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    logic [3:0] wr_slot;
    logic       edge_seen;
    logic       step;

    for (genvar k = 0; k < 4; k++) begin : g_slot
      assign wr_slot[k] = wr_en && (word == 4'(n * 4 + k));
    end

    tmr_tick_sync #(.STAGES(SYNC_LEN)) u_sync (
      .clk  (clk),
      .rst  (rst),
      .pin  (ext_tick[n]),
      .rise (edge_seen)
    );

    assign step      = ctrl[3*n + 1] ? edge_seen : 1'b1;
    assign ovf_en[n] = ctrl[3*n + 2];

    tmr_channel #(.W(W)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .run      (ctrl[3*n]),
      .count_up (ctrl[3*NCH + n]),
      .step     (step),
      .wr_slot  (wr_slot),
      .wdata    (wdata),
      .cnt      (cnt_q[n]),
      .reload   (load_q[n]),
      .cmp_a    (cmpa_q[n]),
      .cmp_b    (cmpb_q[n]),
      .hit_a    (events[3*n]),
      .hit_b    (events[3*n + 1]),
      .wrapped  (events[3*n + 2])
    );
  end

  tmr_irq_ctl #(.NCH(NCH)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .wr_stat (wr_en && (word == WORD_STAT)),
    .wdata   (wdata[STAT_W-1:0]),
    .events  (events),
    .mask    (mask),
    .ovf_en  (ovf_en),
    .status  (status),
    .irq     (irq)
  );

  always_comb begin
    rd_next = '0;
    case (word)
      WORD_CTRL: rd_next[CTRL_W-1:0] = ctrl;
      WORD_STAT: rd_next[STAT_W-1:0] = status;
      WORD_MASK: rd_next[STAT_W-1:0] = mask;
      default: begin
        for (int i = 0; i < NCH; i++) begin
          if (word[3:2] == 2'(i)) begin
            case (word[1:0])
              2'd0:    rd_next = cnt_q[i];
              2'd1:    rd_next = load_q[i];
              2'd2:    rd_next = cmpa_q[i];
              default: rd_next = cmpb_q[i];
            endcase
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int W = 32
) (
  input logic                          clk,
  input logic                          rst,
  input logic [tmr_pkg::ADDR_W-1:0]    addr,
  input logic                          wr_en,
  input logic [tmr_pkg::CTRL_W-1:0]    ctrl,
  input logic [tmr_pkg::STAT_W-1:0]    status,
  input logic [tmr_pkg::STAT_W-1:0]    mask,
  input logic [tmr_pkg::NCH-1:0][W-1:0] cnt_q,
  input logic [tmr_pkg::NCH-1:0]       irq
);
  import tmr_pkg::*;

  // R1: first cycle out of reset shows a quiet block
  p_quiet_after_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> (irq == '0 && status == '0));

  for (genvar b = 0; b < STAT_W; b++) begin : g_bit
    // R8: a flag only drops through a software write
    p_sticky_flag_r8: assert property (@(posedge clk) disable iff (rst)
      $fell(status[b]) |-> $past(wr_en && addr[5:2] == WORD_STAT));
  end

  for (genvar n = 0; n < NCH; n++) begin : g_chk
    // R9: an interrupt needs an unmasked flag one cycle earlier
    p_irq_source_r9: assert property (@(posedge clk) disable iff (rst)
      irq[n] |-> $past((|(status[3*n +: 2] & mask[3*n +: 2])) ||
                       (status[3*n+2] && mask[3*n+2] && ctrl[3*n+2])));
    // R6: a stopped, unwritten channel keeps its count
    p_frozen_count_r6: assert property (@(posedge clk) disable iff (rst)
      (!ctrl[3*n] && !(wr_en && addr[5:2] == 4'(n * 4))) |=> $stable(cnt_q[n]));
  end
endmodule

bind tri_match_timer tmr_checker #(.W(W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .addr   (addr),
  .wr_en  (wr_en),
  .ctrl   (ctrl),
  .status (status),
  .mask   (mask),
  .cnt_q  (cnt_q),
  .irq    (irq)
);

// File: tb/tri_match_timer_tb.sv
`timescale 1ns/1ps
module tri_match_timer_tb;
  logic        clk = 0;
  logic        rst = 1;
  logic [5:0]  addr = '0;
  logic        wr_en = 0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_data;
  logic [2:0]  ext_tick = '0;
  logic [2:0]  irq;
  int nchk = 0;
  int nfail = 0;
  logic [31:0] v;

  always #2 clk = ~clk;

  tri_match_timer u_dut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rd_data(rd_data), .ext_tick(ext_tick), .irq(irq)
  );

  typedef struct packed { logic [5:0] a; logic [31:0] d; logic [31:0] e; } vec_t;
  localparam vec_t VEC [9] = '{
    '{6'h04, 32'hDEADBEEF, 32'hDEADBEEF},
    '{6'h18, 32'h12345678, 32'h12345678},
    '{6'h2C, 32'hA5A5A5A5, 32'hA5A5A5A5},
    '{6'h30, 32'hFFFFF000, 32'h00000000},
    '{6'h38, 32'hFFFFFFFF, 32'h000001FF},
    '{6'h34, 32'hFFFFFE00, 32'h00000000},
    '{6'h20, 32'h00000055, 32'h00000055},
    '{6'h3C, 32'h00000077, 32'h00000000},
    '{6'h38, 32'h00000000, 32'h00000000}
  };

  localparam logic [31:0] L6 = 32'hFFFFFFFA; // 6-tick period

  // all tasks are entered at a falling edge and return at one
  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    addr = a; wr_en = 0;
    @(posedge clk); @(negedge clk);
    d = rd_data;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic quiet();
    wr(6'h30, 0); wr(6'h38, 0); wr(6'h34, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    idle(3);
    rst = 0;
    // R1 reset state
    chk("R1 irq", {29'd0, irq}, 0);
    rd(6'h30, v); chk("R1 ctrl", v, 0);
    rd(6'h34, v); chk("R1 status", v, 0);
    rd(6'h38, v); chk("R1 mask", v, 0);
    rd(6'h00, v); chk("R1 count0", v, 0);
    rd(6'h2C, v); chk("R1 cmpb2", v, 0);

    // R2 register map walk
    for (int i = 0; i < 9; i++) begin
      wr(VEC[i].a, VEC[i].d);
      rd(VEC[i].a, v);
      chk("R2 map", v, VEC[i].e);
    end

    // R3 up count wrap with reload
    quiet();
    wr(6'h04, L6); wr(6'h00, L6); wr(6'h38, 32'h4);
    wr(6'h30, 32'h205);
    idle(6); chk("R3 irq before", {31'd0, irq[0]}, 0);
    idle(1); chk("R3 irq after", {31'd0, irq[0]}, 1);
    rd(6'h34, v); chk("R3 status", v, 32'h4);
    wr(6'h30, 0);
    rd(6'h00, v); chk("R3 reloaded count", v, 32'hFFFFFFFD);

    // R8 software clear on the overflow edge loses to hardware
    quiet();
    wr(6'h00, L6); wr(6'h30, 32'h201);
    idle(5); wr(6'h34, 0);
    rd(6'h34, v); chk("R8 hw wins", v, 32'h4);
    wr(6'h34, 0);
    rd(6'h34, v); chk("R8 clear", v, 0);
    wr(6'h30, 0);

    // R4 down count underflow, channel 1
    quiet();
    wr(6'h10, 2); wr(6'h14, 32'h10); wr(6'h38, 32'h20);
    wr(6'h30, 32'h28);
    idle(3); chk("R4 irq before", {31'd0, irq[1]}, 0);
    idle(1); chk("R4 irq after", {31'd0, irq[1]}, 1);
    wr(6'h30, 0);
    rd(6'h10, v); chk("R4 reloaded count", v, 32'hE);

    // R5 compare A on channel 0, counting up
    quiet();
    wr(6'h00, 100); wr(6'h08, 103); wr(6'h38, 32'h1);
    wr(6'h30, 32'h201);
    idle(3); chk("R5 cmpA irq before", {31'd0, irq[0]}, 0);
    idle(1); chk("R5 cmpA irq after", {31'd0, irq[0]}, 1);
    wr(6'h30, 0);
    rd(6'h34, v); chk("R5 cmpA status", v, 32'h1);

    // R5 compare B on channel 1, counting down
    quiet();
    wr(6'h10, 50); wr(6'h1C, 47); wr(6'h38, 32'h10);
    wr(6'h30, 32'h08);
    idle(3); chk("R5 cmpB irq before", {31'd0, irq[1]}, 0);
    idle(1); chk("R5 cmpB irq after", {31'd0, irq[1]}, 1);
    wr(6'h30, 0);
    rd(6'h34, v); chk("R5 cmpB status", v, 32'h10);

    // R9 overflow term gated by its control enable, and by the mask
    quiet();
    wr(6'h38, 32'h4); wr(6'h00, L6); wr(6'h30, 32'h201);
    idle(10); chk("R9 ovf gated", {31'd0, irq[0]}, 0);
    rd(6'h34, v); chk("R9 flag present", v, 32'h4);
    wr(6'h30, 0); wr(6'h38, 0); wr(6'h30, 32'h004);
    idle(3); chk("R9 mask blocks", {31'd0, irq[0]}, 0);
    wr(6'h38, 32'h4);
    idle(2); chk("R9 mask passes", {31'd0, irq[0]}, 1);

    // R6 stop freezes, written value resumes (channel 2, up)
    quiet();
    wr(6'h20, 32'h55);
    wr(6'h30, 32'h840); idle(2); wr(6'h30, 0);
    idle(5);
    rd(6'h20, v); chk("R6 frozen", v, 32'h58);
    wr(6'h20, 32'h1000);
    wr(6'h30, 32'h840); wr(6'h30, 0);
    rd(6'h20, v); chk("R6 resume", v, 32'h1001);

    // R7 external tick edges on channel 2
    wr(6'h20, 0);
    wr(6'h30, 32'h8C0);
    idle(10);
    rd(6'h20, v); chk("R7 no edges", v, 0);
    ext_tick[2] = 1; idle(8);
    rd(6'h20, v); chk("R7 held high", v, 1);
    ext_tick[2] = 0; idle(3);
    for (int p = 0; p < 3; p++) begin
      ext_tick[2] = 1; idle(3);
      ext_tick[2] = 0; idle(3);
    end
    idle(4);
    rd(6'h20, v); chk("R7 four edges", v, 4);
    wr(6'h30, 0);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule